// File: doc/BRIEF.md
# Master-Slave Gated Timer Pair

Two identical up-counting timers share one kernel clock and are joined by a trigger path. Each timer divides the clock by a programmable ratio, counts up to a reload value and wraps to zero. It also derives a compare reference level from its counter, and can publish that level as its trigger output. A timer running in gated mode advances only while its selected trigger input is high. With timer 0 set as master and timer 1 as slave, the slave therefore accumulates the number of prescaled ticks for which the master's counter sits below its compare value.

Software programs both timers through one write port. The port selects the target timer, a 3-bit register address and a data word. The counters, the trigger outputs and the trigger flags are brought straight out as ports. The gate decides only whether the slave counts. The slave keeps its own prescaler phase and its counter value across gate intervals. Starting a timer never clears its state; only an explicit update event or a counter write does.

Top module: `gated_timer_pair`

## Requirements
- R1: After reset both counters read 0, both trigger outputs and both trigger flags are 0, both timers are disabled, and the reload value is all ones with prescale ratio 0 and compare 0.
- R2: An enabled, ungated timer advances its counter once every ratio+1 clock edges (ratio written at address 6), and wraps from a value at or above the reload value (address 7) to 0.
- R3: On every edge where the timer is enabled, the compare reference is updated to (counter < compare), where compare is written at address 2. While the timer is disabled the reference holds its value.
- R4: When mode bits [2:0] (address 1) equal 3'b100, the trigger output follows the compare reference. Any other code drives it to 0.
- R5: When mode bits [7:3] equal 5'b00010, the trigger input is the other timer's trigger output. Any other code holds the trigger input at 0.
- R6: When mode bits [10:8] equal 3'b101 (gated), the counter and the prescaler advance only on edges where the trigger input is high. With any other code the timer counts whenever it is enabled.
- R7: Setting or clearing the enable bit (address 0, bit 0) never clears the counter or the prescaler. Counting resumes from the held values.
- R8: A write to address 4 with bit 0 set is an update event. It clears the counter and the prescaler at that edge, overriding any count.
- R9: A write to address 5 loads the counter with any value at that edge, overriding any count.
- R10: In gated mode, each rising or falling change of the trigger input sets the trigger flag. Writing 0 to bit 0 of address 3 clears the flag, and writing 1 leaves it unchanged. A trigger change in the same edge as a clear wins.
- R11: All register writes take effect at the clock edge where the write strobe is high. Timer 0 is addressed when the target input is 0 and timer 1 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared kernel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 1 | 0 selects timer 0 (master), 1 selects timer 1 (slave) |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| mst_count | output | CNT_W | Timer 0 counter |
| slv_count | output | CNT_W | Timer 1 counter |
| mst_trgo | output | 1 | Timer 0 trigger output |
| slv_trgo | output | 1 | Timer 1 trigger output |
| mst_flag | output | 1 | Timer 0 trigger flag |
| slv_flag | output | 1 | Timer 1 trigger flag |

## Verification
The bench runs both timers against a behavioural model through several master compare/reload/prescale settings and slave start values. These include a compare of 0, which keeps the gate shut, a compare above the reload value, which keeps it open, and a slave start near the top of the count range. A design that re-phased or cleared the slave prescaler when the gate opened would drift from the model. One that cleared state on enable would fail the resume-from-held-value test. The bench also stops the master while its reference is high: a design that dropped the reference on disable would halt the slave early. Further tests cover a wrong trigger-select code, which must keep the gate shut, and a flag write of 1, which must not clear the flag.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_MODE   = 3'd1;
    localparam logic [2:0] ADDR_CMP    = 3'd2;
    localparam logic [2:0] ADDR_FLAG   = 3'd3;
    localparam logic [2:0] ADDR_EVENT  = 3'd4;
    localparam logic [2:0] ADDR_COUNT  = 3'd5;
    localparam logic [2:0] ADDR_PRESC  = 3'd6;
    localparam logic [2:0] ADDR_RELOAD = 3'd7;

    localparam logic [2:0] OSEL_CMP_REF = 3'b100;
    localparam logic [4:0] TSEL_PEER    = 5'b00010;
    localparam logic [2:0] SMODE_GATED  = 3'b101;

    localparam int MODE_W = 11;

    typedef struct packed {
        logic [2:0] smode;
        logic [4:0] tsel;
        logic [2:0] osel;
    } mode_t;

endpackage

// File: rtl/gtp_prescaler.sv
module gtp_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] ratio,
    output logic             tick
);

    logic [PSC_W-1:0] psc_d, psc_q;

    assign tick = run && (psc_q >= ratio);

    always_comb begin
        psc_d = psc_q;
        if (clr) begin
            psc_d = '0;
        end else if (run) begin
            psc_d = tick ? '0 : psc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    // R8: an update event leaves the prescaler at zero
    a_r8_psc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (psc_q == '0));

    // R6/R7: no run, no clear -> phase is kept
    a_r7_psc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(psc_q));

endmodule

// File: rtl/gtp_gate.sv
module gtp_gate
    import gtp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       peer_trgo,
    input  logic [4:0] tsel,
    input  logic [2:0] smode,
    output logic       trig,
    output logic       gate_open,
    output logic       edge_seen
);

    logic prev_d, prev_q;
    logic gated;

    assign gated     = (smode == SMODE_GATED);
    assign trig      = (tsel == TSEL_PEER) ? peer_trgo : 1'b0;
    assign gate_open = gated ? trig : 1'b1;
    assign edge_seen = gated && (trig != prev_q);

    always_comb begin
        prev_d = trig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R5: an unselected source never reaches the trigger input
    a_r5_unselected_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel != TSEL_PEER) |-> !edge_seen || (prev_q && !trig));

endmodule

// File: rtl/gtp_timer.sv
module gtp_timer
    import gtp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              peer_trgo,
    output logic [CNT_W-1:0]  count,
    output logic              trgo,
    output logic              flag
);

    typedef struct packed {
        logic             en;
        mode_t            mode;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] arr;
        logic [PSC_W-1:0] ratio;
        logic [CNT_W-1:0] cnt;
        logic             ref_lvl;
        logic             flag;
    } tmr_state_t;

    tmr_state_t s_d, s_q;

    logic trig, gate_open, edge_seen;
    logic tick, run;
    logic cnt_wr, upd_ev;

    assign cnt_wr = wr_en && (wr_addr == ADDR_COUNT);
    assign upd_ev = wr_en && (wr_addr == ADDR_EVENT) && wr_data[0];
    assign run    = s_q.en && gate_open;

    gtp_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .peer_trgo (peer_trgo),
        .tsel      (s_q.mode.tsel),
        .smode     (s_q.mode.smode),
        .trig      (trig),
        .gate_open (gate_open),
        .edge_seen (edge_seen)
    );

    gtp_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (upd_ev),
        .ratio (s_q.ratio),
        .tick  (tick)
    );

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.cnt = (s_q.cnt >= s_q.arr) ? '0 : s_q.cnt + 1'b1;
        end
        if (s_q.en) begin
            s_d.ref_lvl = (s_q.cnt < s_q.cmp);
        end
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:   s_d.en    = wr_data[0];
                ADDR_MODE:   s_d.mode  = mode_t'(wr_data[MODE_W-1:0]);
                ADDR_CMP:    s_d.cmp   = wr_data[CNT_W-1:0];
                ADDR_FLAG:   if (!wr_data[0]) s_d.flag = 1'b0;
                ADDR_EVENT:  if (wr_data[0]) s_d.cnt = '0;
                ADDR_COUNT:  s_d.cnt   = wr_data[CNT_W-1:0];
                ADDR_PRESC:  s_d.ratio = wr_data[PSC_W-1:0];
                ADDR_RELOAD: s_d.arr   = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
        if (edge_seen) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.arr     <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;
    assign trgo  = (s_q.mode.osel == OSEL_CMP_REF) && s_q.ref_lvl;
    assign flag  = s_q.flag;

    // R3: a stopped timer keeps its reference level
    a_r3_ref_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |=> $stable(s_q.ref_lvl));

    // R7: a disabled timer without writes keeps its count
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.en && !cnt_wr && !upd_ev) |=> $stable(s_q.cnt));

    // R6: closed gate holds the count
    a_r6_gate_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !cnt_wr && !upd_ev) |=> $stable(s_q.cnt));

    // R2: counting moves by one step or wraps to zero
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !upd_ev) |=> (s_q.cnt == $past(s_q.cnt)
                                  || s_q.cnt == CNT_W'($past(s_q.cnt) + 1'b1)
                                  || s_q.cnt == '0));

    // R8: update event clears the counter
    a_r8_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ev |=> (s_q.cnt == '0));

    // R10: the flag only rises on a trigger change
    a_r10_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.flag && !edge_seen) |=> !s_q.flag);

endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair #(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_target,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  mst_count,
    output logic [CNT_W-1:0]  slv_count,
    output logic              mst_trgo,
    output logic              slv_trgo,
    output logic              mst_flag,
    output logic              slv_flag
);

    localparam int N_TMR = 2;

    logic [CNT_W-1:0] cnt_w  [N_TMR];
    logic             trgo_w [N_TMR];
    logic             flag_w [N_TMR];

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic sel_wr;
        assign sel_wr = wr_en && (wr_target == 1'(i));

        gtp_timer #(
            .CNT_W  (CNT_W),
            .PSC_W  (PSC_W),
            .DATA_W (DATA_W)
        ) i_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_wr),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .peer_trgo (trgo_w[N_TMR-1-i]),
            .count     (cnt_w[i]),
            .trgo      (trgo_w[i]),
            .flag      (flag_w[i])
        );

        // R11: an unaddressed timer's counter is untouched by writes
        a_r11_target_only: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_target != 1'(i) && wr_addr == 3'd5 && !trgo_w[N_TMR-1-i])
            |=> (cnt_w[i] == $past(cnt_w[i]) || cnt_w[i] == CNT_W'($past(cnt_w[i]) + 1'b1)
                 || cnt_w[i] == '0));
    end

    assign mst_count = cnt_w[0];
    assign slv_count = cnt_w[1];
    assign mst_trgo  = trgo_w[0];
    assign slv_trgo  = trgo_w[1];
    assign mst_flag  = flag_w[0];
    assign slv_flag  = flag_w[1];

endmodule

// File: tb/test_gated_timer_pair.sv
module test_gated_timer_pair;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_target = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] mst_count, slv_count;
    logic         mst_trgo, slv_trgo, mst_flag, slv_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gated_timer_pair #(.CNT_W(W), .PSC_W(W), .DATA_W(W)) i_gated_timer_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .mst_count(mst_count), .slv_count(slv_count),
        .mst_trgo(mst_trgo), .slv_trgo(slv_trgo),
        .mst_flag(mst_flag), .slv_flag(slv_flag)
    );

    // Behavioural model built from the requirements (index 0 master, 1 slave)
    logic         m_en [2];
    logic [10:0]  m_mode [2];
    logic [W-1:0] m_cmp [2], m_arr [2], m_ratio [2], m_cnt [2], m_psc [2];
    logic         m_ref [2], m_flag [2], m_prev [2];

    function automatic logic mdl_trgo(int i);
        return (m_mode[i][2:0] == 3'b100) && m_ref[i];
    endfunction

    always @(posedge clk) begin
        logic trig [2];
        logic n_ref [2], n_flag [2];
        logic [W-1:0] n_cnt [2], n_psc [2];
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_en[i] = 0; m_mode[i] = '0; m_cmp[i] = '0; m_arr[i] = '1;
                m_ratio[i] = '0; m_cnt[i] = '0; m_psc[i] = '0;
                m_ref[i] = 0; m_flag[i] = 0; m_prev[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++)
                trig[i] = (m_mode[i][7:3] == 5'b00010) ? mdl_trgo(1 - i) : 1'b0;
            for (int i = 0; i < 2; i++) begin
                logic gated, open, run, tk;
                gated = (m_mode[i][10:8] == 3'b101);
                open  = gated ? trig[i] : 1'b1;
                run   = m_en[i] && open;
                tk    = run && (m_psc[i] >= m_ratio[i]);
                n_psc[i] = run ? (tk ? '0 : m_psc[i] + 1'b1) : m_psc[i];
                n_cnt[i] = tk ? ((m_cnt[i] >= m_arr[i]) ? '0 : m_cnt[i] + 1'b1) : m_cnt[i];
                n_ref[i] = m_en[i] ? (m_cnt[i] < m_cmp[i]) : m_ref[i];
                n_flag[i] = m_flag[i];
                if (wr_en && wr_target == 1'(i) && wr_addr == 3'd3 && !wr_data[0]) n_flag[i] = 0;
                if (gated && trig[i] != m_prev[i]) n_flag[i] = 1;
                if (wr_en && wr_target == 1'(i)) begin
                    case (wr_addr)
                        3'd0: m_en[i] = wr_data[0];
                        3'd1: m_mode[i] = wr_data[10:0];
                        3'd2: m_cmp[i] = wr_data;
                        3'd4: if (wr_data[0]) begin n_cnt[i] = '0; n_psc[i] = '0; end
                        3'd5: n_cnt[i] = wr_data;
                        3'd6: m_ratio[i] = wr_data;
                        3'd7: m_arr[i] = wr_data;
                        default: ;
                    endcase
                end
            end
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = n_cnt[i]; m_psc[i] = n_psc[i]; m_ref[i] = n_ref[i];
                m_flag[i] = n_flag[i]; m_prev[i] = trig[i];
            end
        end
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic tgt, logic [2:0] a, logic [W-1:0] d);
        wr_en = 1'b1; wr_target = tgt; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [W-1:0] mpsc, mcmp, marr, spsc, sstart, cycles;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{16'd0, 16'd4,  16'd9, 16'd0, 16'h00E7, 16'd40},
        '{16'd1, 16'd3,  16'd5, 16'd2, 16'h0010, 16'd50},
        '{16'd0, 16'd0,  16'd7, 16'd0, 16'h0005, 16'd30},
        '{16'd0, 16'd20, 16'd7, 16'd0, 16'hFFFE, 16'd20}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 mst_count", mst_count, '0);
        check("R1 slv_count", slv_count, '0);
        check("R1 trgo", {14'd0, mst_trgo, slv_trgo}, '0);
        check("R1 flags", {14'd0, mst_flag, slv_flag}, '0);

        // Vector table against the model (R2 R3 R4 R5 R6 R10)
        foreach (ROWS[r]) begin
            wr(0, 3'd0, 0); wr(1, 3'd0, 0);
            wr(0, 3'd4, 1); wr(1, 3'd4, 1);
            wr(0, 3'd1, 16'h0004); wr(1, 3'd1, 16'h0510);
            wr(0, 3'd6, ROWS[r].mpsc); wr(0, 3'd2, ROWS[r].mcmp); wr(0, 3'd7, ROWS[r].marr);
            wr(1, 3'd6, ROWS[r].spsc); wr(1, 3'd7, 16'hFFFF); wr(1, 3'd5, ROWS[r].sstart);
            wr(1, 3'd3, 0);
            wr(1, 3'd0, 1); wr(0, 3'd0, 1);
            idle(int'(ROWS[r].cycles));
            check("R6 gated slave count", slv_count, m_cnt[1]);
            check("R2 master count", mst_count, m_cnt[0]);
            check("R10 slave flag", {15'd0, slv_flag}, {15'd0, m_flag[1]});
            check("R4 master trgo", {15'd0, mst_trgo}, {15'd0, mdl_trgo(0)});
            wr(0, 3'd0, 0);
            idle(6);
            check("R3 slave after master stop", slv_count, m_cnt[1]);
        end

        // R10 flag write semantics (slave ungated, master stopped)
        wr(1, 3'd0, 0); wr(1, 3'd1, 16'h0000);
        check("R10 flag set by table", {15'd0, slv_flag}, 16'd1);
        wr(1, 3'd3, 1);
        check("R10 write 1 keeps flag", {15'd0, slv_flag}, 16'd1);
        wr(1, 3'd3, 0);
        check("R10 write 0 clears flag", {15'd0, slv_flag}, 16'd0);

        // R2 / R7 / R11 free count and resume
        wr(1, 3'd6, 0); wr(1, 3'd4, 1); wr(1, 3'd5, 16'h0030); wr(1, 3'd0, 1);
        idle(5);
        check("R2 free count", slv_count, 16'h0035);
        wr(1, 3'd0, 0);
        idle(3);
        wr(1, 3'd0, 1);
        idle(2);
        check("R7 resume without clear", slv_count, 16'h0038);

        // R8 update event while running
        wr(1, 3'd4, 1);
        check("R8 event clears", slv_count, 16'h0000);
        idle(1);
        check("R8 count after event", slv_count, 16'h0001);

        // R9 counter write while running
        wr(1, 3'd5, 16'h1234);
        check("R9 write overrides count", slv_count, 16'h1234);
        idle(1);
        check("R9 count after write", slv_count, 16'h1235);

        // R4 trigger output select, R3 frozen reference
        wr(0, 3'd4, 1); wr(0, 3'd2, 16'd10); wr(0, 3'd7, 16'hFFFF); wr(0, 3'd6, 0);
        wr(0, 3'd1, 16'h0004); wr(0, 3'd0, 1);
        idle(2);
        check("R4 trgo follows reference", {15'd0, mst_trgo}, 16'd1);
        wr(0, 3'd1, 16'h0000);
        check("R4 other code drives 0", {15'd0, mst_trgo}, 16'd0);
        wr(0, 3'd1, 16'h0004); wr(0, 3'd0, 0);
        idle(20);
        check("R3 reference frozen high", {15'd0, mst_trgo}, 16'd1);

        // R5 trigger select
        wr(1, 3'd0, 0); wr(1, 3'd4, 1); wr(1, 3'd1, 16'h0500); wr(1, 3'd0, 1);
        idle(4);
        check("R5 wrong select keeps gate shut", slv_count, 16'h0000);
        wr(1, 3'd1, 16'h0510);
        idle(4);
        check("R5 peer select opens gate", slv_count, 16'h0004);
        check("R10 rising edge sets flag", {15'd0, slv_flag}, 16'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule